// File: doc/BRIEF.md
# Banked Configurable Interrupt Controller

This block gathers a wide set of interrupt sources into groups of up to 32 and turns them into one request line per group. Every source has its own trigger type, picked by two configuration bits: level active high, level active low, rising edge or falling edge. Each source input is synchronized to the block clock before any detection. Edge sources record their event in a pending flag that stays set until software clears it. Level sources show the corrected input level directly.

Each group ANDs its pending flags with its enable mask and raises its request line while any enabled flag is set. A plain register bus reaches all registers. Writes take effect at the next clock edge. Reads return data in the same cycle and change no state. Every group has the same register layout, and the groups repeat at a fixed byte stride.

Top module: `bic_top`

## Requirements
- R1: After reset, each group's enable mask, trigger-type register and pending flags read 0, its polarity register reads all ones, and every request line is low.
- R2: Group g's registers start at byte address g*0x18 and sit at these offsets from that base: 0x00 pending (read only), 0x04 enable, 0x08 force, 0x0C clear, 0x10 polarity, 0x14 trigger type. Source n is bit (n mod 32) of group (n div 32).
- R3: When polarity=1 and trigger type=0, the pending bit equals the input level. A change on the input shows in the pending bit three clock edges later and not earlier.
- R4: When polarity=0 and trigger type=0, the pending bit equals the inverted input level.
- R5: When polarity=1 and trigger type=1, a 0-to-1 input transition sets the pending bit. The bit then stays set after the input returns low.
- R6: When polarity=0 and trigger type=1, a 1-to-0 transition sets the pending bit, and a 0-to-1 transition does not.
- R7: Writing 1 to a bit of the clear register clears that edge-mode pending bit, and bits written as 0 leave their flags untouched. On a level source that is still active, a clear has no lasting effect.
- R8: Writing 1 to a bit of the force register sets that pending bit. On an edge source the bit then holds until it is cleared.
- R9: The force and clear registers read back as 0. Unused or unaligned addresses also read 0.
- R10: Request line g is high exactly when group g has a pending bit whose enable bit is also 1. Other groups' lines are not affected.
- R11: An edge source records a given transition only once. Clearing the flag while the input stays at its new level leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*BANK_W | Interrupt source inputs, may be asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, same cycle |
| irq_o | output | NUM_BANKS | One request line per group |

## Verification
Trigger detection is exercised with four input shapes on sources in different groups: a high pulse, a low pulse, a single rise and a single fall. A rise on a falling-edge source must leave its flag clear, which separates edge polarity from edge detection. A source held high after being cleared shows whether detection compares against the previous sample or against the level. Clear writes with the target bit at 0, and clears on an active level source, separate a sticky latch from a level that is reloaded every cycle. An enable sweep on one group, while the other groups stay idle, tests the masking and the independence of the groups.

// File: rtl/bic_pkg.sv
package bic_pkg;

   // Register selector decoded from the offset within one group.
   typedef enum logic [2:0] {
      SEL_PEND,
      SEL_ENABLE,
      SEL_FORCE,
      SEL_CLEAR,
      SEL_POLARITY,
      SEL_TRIGGER,
      SEL_NONE
   } reg_sel_e;

   localparam int unsigned BANK_SPAN = 24;   // bytes occupied by one group
   localparam int unsigned MAX_BANKS = 5;

   function automatic reg_sel_e decode_offset(input logic [4:0] off);
      case (off)
         5'h00:   decode_offset = SEL_PEND;
         5'h04:   decode_offset = SEL_ENABLE;
         5'h08:   decode_offset = SEL_FORCE;
         5'h0C:   decode_offset = SEL_CLEAR;
         5'h10:   decode_offset = SEL_POLARITY;
         5'h14:   decode_offset = SEL_TRIGGER;
         default: decode_offset = SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] prev_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("bic_sync: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [SYNC_STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[SYNC_STAGES-1];
      end
   end

   assign sync_o = stage_q[SYNC_STAGES-1];
   assign prev_o = prev_q;

   // Cycles since reset, used only to bound the look-back of the check.
   logic [1:0] warm_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   if (SYNC_STAGES == 2) begin : g_chk2
      // R3
      sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (warm_q >= 2'd2) |-> (sync_o == $past(async_i, 2)));
   end

endmodule

// File: rtl/bic_trigger.sv
module bic_trigger #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] sync_i,
   input  logic [WIDTH-1:0] prev_i,
   input  logic [WIDTH-1:0] pol_i,
   input  logic [WIDTH-1:0] edge_sel_i,
   output logic [WIDTH-1:0] active_o,
   output logic [WIDTH-1:0] event_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic rise, fall;
      assign rise        = sync_i[i] & ~prev_i[i];
      assign fall        = ~sync_i[i] & prev_i[i];
      assign active_o[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];
      assign event_o[i]  = edge_sel_i[i] & (pol_i[i] ? rise : fall);
   end

endmodule

// File: rtl/bic_bank.sv
module bic_bank
   import bic_pkg::*;
#(
   parameter int unsigned BANK_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BASE   = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [BANK_W-1:0] sync_i,
   input  logic [BANK_W-1:0] prev_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(BANK_SPAN);

   logic [ADDR_W-1:0] rel;
   logic              in_rng;
   reg_sel_e          sel;

   assign rel    = addr_i - BASE_A;
   assign in_rng = (addr_i >= BASE_A) && (rel < SPAN_A);
   assign sel    = in_rng ? decode_offset(rel[4:0]) : SEL_NONE;

   logic              en_wr, pol_wr, trig_wr;
   logic [BANK_W-1:0] force_bits, clr_bits, wbits;

   assign wbits      = wdata_i[BANK_W-1:0];
   assign en_wr      = wr_i && (sel == SEL_ENABLE);
   assign pol_wr     = wr_i && (sel == SEL_POLARITY);
   assign trig_wr    = wr_i && (sel == SEL_TRIGGER);
   assign force_bits = (wr_i && (sel == SEL_FORCE)) ? wbits : '0;
   assign clr_bits   = (wr_i && (sel == SEL_CLEAR)) ? wbits : '0;

   logic [BANK_W-1:0] en_q, pol_q, trig_q, pend_q, pend_d;
   logic [BANK_W-1:0] active, evt;

   bic_trigger #(.WIDTH(BANK_W)) u_trig (
      .sync_i     (sync_i),
      .prev_i     (prev_i),
      .pol_i      (pol_q),
      .edge_sel_i (trig_q),
      .active_o   (active),
      .event_o    (evt)
   );

   // Level bits reload from the input each cycle; edge bits are sticky.
   for (genvar i = 0; i < BANK_W; i++) begin : g_next
      always_comb begin
         if (trig_q[i]) pend_d[i] = (pend_q[i] & ~clr_bits[i]) | evt[i] | force_bits[i];
         else           pend_d[i] = active[i] | force_bits[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         pol_q  <= '1;
         trig_q <= '0;
         pend_q <= '0;
      end else begin
         if (en_wr)   en_q   <= wbits;
         if (pol_wr)  pol_q  <= wbits;
         if (trig_wr) trig_q <= wbits;
         pend_q <= pend_d;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_PEND:     rdata_o[BANK_W-1:0] = pend_q;
         SEL_ENABLE:   rdata_o[BANK_W-1:0] = en_q;
         SEL_POLARITY: rdata_o[BANK_W-1:0] = pol_q;
         SEL_TRIGGER:  rdata_o[BANK_W-1:0] = trig_q;
         default:      rdata_o = '0;
      endcase
   end

   assign irq_o = |(pend_q & en_q);

   // R10
   mask_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_wr && (wbits == '0)) |=> !irq_o);

   for (genvar i = 0; i < BANK_W; i++) begin : g_chk
      // R5
      edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (trig_q[i] && pend_q[i] && !clr_bits[i] && !trig_wr) |=> pend_q[i]);
      // R7
      edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (trig_q[i] && clr_bits[i] && !force_bits[i] && !evt[i] && !trig_wr)
         |=> !pend_q[i]);
      // R3
      level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!trig_q[i] && !force_bits[i] && !trig_wr) |=> (pend_q[i] == $past(active[i])));
   end

endmodule

// File: rtl/bic_top.sv
module bic_top
   import bic_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 5,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STRIDE      = BANK_SPAN
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_BANKS*BANK_W-1:0] src_i,
   input  logic                        bus_wr_i,
   input  logic [ADDR_W-1:0]           bus_addr_i,
   input  logic [DATA_W-1:0]           bus_wdata_i,
   output logic [DATA_W-1:0]           bus_rdata_o,
   output logic [NUM_BANKS-1:0]        irq_o
);

   localparam int unsigned SRC_W = NUM_BANKS * BANK_W;

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("bic_top: NUM_BANKS out of range");
   end
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_width
      $error("bic_top: BANK_W must be 1..DATA_W");
   end
   if (STRIDE < BANK_SPAN || (STRIDE % 4) != 0) begin : g_bad_stride
      $error("bic_top: STRIDE too small or unaligned");
   end
   if (ADDR_W < 5 || (NUM_BANKS * STRIDE) > (1 << ADDR_W)) begin : g_bad_addr
      $error("bic_top: ADDR_W too narrow for the register map");
   end

   logic [SRC_W-1:0]  src_sync, src_prev;
   logic [DATA_W-1:0] rd_bank [NUM_BANKS];

   bic_sync #(.WIDTH(SRC_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (src_i),
      .sync_o  (src_sync),
      .prev_o  (src_prev)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bic_bank #(
         .BANK_W (BANK_W),
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W),
         .BASE   (b * STRIDE)
      ) u_bank (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .wr_i    (bus_wr_i),
         .addr_i  (bus_addr_i),
         .wdata_i (bus_wdata_i),
         .sync_i  (src_sync[b*BANK_W +: BANK_W]),
         .prev_i  (src_prev[b*BANK_W +: BANK_W]),
         .rdata_o (rd_bank[b]),
         .irq_o   (irq_o[b])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) bus_rdata_o = bus_rdata_o | rd_bank[b];
   end

endmodule

// File: tb/bic_top_tb.sv
module bic_top_tb_top;

   localparam int  NB       = 5;
   localparam int  BW       = 32;
   localparam time CLK_HALF = 5ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NB*BW-1:0] src = '0;
   logic           wr = 1'b0;
   logic [7:0]     addr = '0;
   logic [31:0]    wdata = '0;
   logic [31:0]    rdata;
   logic [NB-1:0]  irq;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   bic_top dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .src_i       (src),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_rd(8'h04, d); check("R1 enable g0", d, 32'h0);
      reg_rd(8'h10, d); check("R1 polarity g0", d, 32'hFFFF_FFFF);
      reg_rd(8'h14, d); check("R1 trigger g0", d, 32'h0);
      reg_rd(8'h60, d); check("R1 pending g4", d, 32'h0);
      reg_rd(8'h70, d); check("R1 polarity g4", d, 32'hFFFF_FFFF);
      check("R1 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_level_high();
      logic [31:0] d;
      reg_wr(8'h04, 32'h8);              // enable source 3
      src[3] = 1'b1;
      cycles(2);
      reg_rd(8'h00, d); check("R3 latency", d, 32'h0);
      cycles(1);
      reg_rd(8'h00, d); check("R3 high level", d, 32'h8);
      check("R10 irq g0 on", 32'(irq), 32'h1);
      src[3] = 1'b0;
      cycles(3);
      reg_rd(8'h00, d); check("R3 level drop", d, 32'h0);
      check("R10 irq g0 off", 32'(irq), 32'h0);
   endtask

   task automatic t_level_low();
      logic [31:0] d;
      reg_wr(8'h28, 32'hFFFF_FEFF);      // source 40: group 1 bit 8
      cycles(2);
      reg_rd(8'h18, d); check("R4 low level active", d, 32'h100);
      reg_wr(8'h24, 32'h100);
      cycles(2);
      reg_rd(8'h18, d); check("R7 clear on active level", d, 32'h100);
      src[40] = 1'b1;
      cycles(3);
      reg_rd(8'h18, d); check("R4 low level idle", d, 32'h0);
   endtask

   task automatic t_rising();
      logic [31:0] d;
      reg_wr(8'h44, 32'h40);             // source 70: group 2 bit 6
      src[70] = 1'b1;
      cycles(3);
      reg_rd(8'h30, d); check("R5 rise latched", d, 32'h40);
      src[70] = 1'b0;
      cycles(3);
      reg_rd(8'h30, d); check("R5 held after drop", d, 32'h40);
      reg_wr(8'h3C, 32'hFFFF_FFBF);
      reg_rd(8'h30, d); check("R7 zero bit no effect", d, 32'h40);
      reg_wr(8'h3C, 32'h40);
      reg_rd(8'h30, d); check("R7 clear by one", d, 32'h0);
   endtask

   task automatic t_once();
      logic [31:0] d;
      src[70] = 1'b1;
      cycles(3);
      reg_rd(8'h30, d); check("R11 second rise", d, 32'h40);
      reg_wr(8'h3C, 32'h40);
      cycles(5);
      reg_rd(8'h30, d); check("R11 held high stays clear", d, 32'h0);
      src[70] = 1'b0;
      cycles(3);
      reg_rd(8'h30, d); check("R11 fall ignored on rising", d, 32'h0);
   endtask

   task automatic t_falling();
      logic [31:0] d;
      reg_wr(8'h5C, 32'h10);             // source 100: group 3 bit 4
      reg_wr(8'h58, 32'hFFFF_FFEF);
      cycles(2);
      reg_rd(8'h48, d); check("R6 idle after config", d, 32'h0);
      src[100] = 1'b1;
      cycles(3);
      reg_rd(8'h48, d); check("R6 rise ignored", d, 32'h0);
      src[100] = 1'b0;
      cycles(3);
      reg_rd(8'h48, d); check("R6 fall latched", d, 32'h10);
   endtask

   task automatic t_force_and_reads();
      logic [31:0] d;
      reg_wr(8'h74, 32'h1);              // group 4 bit 0 edge mode
      reg_wr(8'h68, 32'h1);
      cycles(3);
      reg_rd(8'h60, d); check("R8 forced pending held", d, 32'h1);
      reg_rd(8'h68, d); check("R9 force reads 0", d, 32'h0);
      reg_rd(8'h6C, d); check("R9 clear reads 0", d, 32'h0);
      reg_rd(8'h78, d); check("R9 unmapped reads 0", d, 32'h0);
      reg_rd(8'h16, d); check("R9 unaligned reads 0", d, 32'h0);
      check("R10 masked pending", 32'(irq), 32'h0);
   endtask

   task automatic t_mask();
      reg_wr(8'h64, 32'h1);
      check("R10 g4 only", 32'(irq), 32'h10);
      reg_wr(8'h64, 32'h0);
      check("R10 g4 masked again", 32'(irq), 32'h0);
      reg_wr(8'h04, 32'h0);
      reg_wr(8'h4C, 32'h10);             // enable group 3 latched bit
      check("R2 g3 line", 32'(irq), 32'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level_high();
      t_level_low();
      t_rising();
      t_once();
      t_falling();
      t_force_and_reads();
      t_mask();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule